// File: doc/BRIEF.md
# Command FIFO Status Engine

This block is the device-side command lifecycle for a byte-wide FIFO-style secure-module interface. A host reaches it through a small register port: one address holds a status byte, one an extended status byte, and one a data port through which command bytes go in and response bytes come out. The block walks through four phases: Ready, Reception, Execution and Completion. The status byte tells the host which phase it is in, whether more command bytes are wanted, and whether response bytes are waiting.

The command length comes from the header. Bytes 2 to 5 of each command form a big-endian 32-bit size. Once the command is fully loaded, the host writes the go bit. The block then hands the command to an internal stub executor through a start/done handshake. The executor answers after a fixed number of cycles. A fixed ten-byte response is then streamed back through the data port.

The host can cancel while the command is executing, and the response then carries a cancelled result code. The host can replay the response from its first byte. It can also write the ready bit to return the block to Ready and clear everything.

Top module: `tpm_fifo_status`

## Requirements
- R1: After reset the block is in Ready. The status byte reads 0xC4 and the data port reads 0x00.
- R2: Status byte bits are as follows. Bit 7 (valid) and bit 2 (self-test done) always read 1. Bit 6 (ready) reads 1 only in Ready. Bit 4 (response waiting) reads 1 only in Completion while unread response bytes remain. Bits 5, 1 and 0 read 0. Address 3 reads 0x00.
- R3: A data write (address 2) in Ready or Reception stores one byte while the byte count is below the larger of 6 and the header size. The size is taken big-endian from bytes 2..5. Bit 3 (more wanted) reads 1 in Reception exactly while that condition holds. Surplus bytes are dropped.
- R4: Writing 1 to status bit 5 moves Reception to Execution only when bit 3 is 0. The write is ignored in every other case.
- R5: Execution lasts EXEC_LAT cycles (default 8). The response is 10 bytes: the two command tag bytes, then 00 00 00 0A, then a four-byte result code of 0x00000000. Each read strobe on address 2 returns the current byte and advances. Once all bytes have been read, the port reads 0x00 and does not advance.
- R6: Writing 1 to extended status bit 0 in Execution goes straight to Completion with the result code 0x00000909. This takes precedence over an executor done in the same cycle. The same write is ignored in Ready, Reception and Completion.
- R7: Writing 1 to status bit 1 in Completion rewinds the response to byte 0. The write is ignored in other phases.
- R8: Writing 1 to status bit 6 outside Reception returns to Ready, clears the loaded command and the response, and aborts the executor. The write is ignored in Reception.
- R9: The extended status byte (address 1) reads 0x04. This is family code 01 in bits 3:2.
- R10: Data writes in Execution or Completion have no effect. Data reads outside Completion read 0x00 and have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | 0 status, 1 extended status, 2 data port, 3 reserved |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe (advances the response only at address 2) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register, combinational |

## Verification
A wrong phase shows up in the very next status read, because the ready, more-wanted and response-waiting bits are decoded straight from the phase and counters. A wrong byte count or size field shows up as bit 3 falling on the wrong byte, or as go being accepted or refused on the wrong cycle. A wrong read pointer or result flag shows up on the first data-port read after Completion. The bench compares the read port against a behavioural model on every cycle, so any divergence is reported in the cycle where it first becomes visible.

// File: rtl/tpm_fifo_pkg.sv
package tpm_fifo_pkg;

  typedef enum logic [1:0] {
    PH_READY = 2'd0,
    PH_RECV  = 2'd1,
    PH_EXEC  = 2'd2,
    PH_DONE  = 2'd3
  } phase_t;

  localparam logic [1:0] ADDR_STS  = 2'd0;
  localparam logic [1:0] ADDR_EXT  = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int HDR_BYTES = 6;
  localparam int RESP_LEN  = 10;

  // control -> datapath strobes
  typedef struct packed {
    logic clrAll;
    logic takeByte;
    logic rewind;
    logic popByte;
    logic markCancel;
    logic markOk;
  } dpCtl_t;

endpackage

// File: rtl/tpm_exec_stub.sv
module tpm_exec_stub #(
  parameter int EXEC_LAT = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic execStart,
  input  logic execAbort,
  output logic execDone
);
  localparam int LAT_W = $clog2(EXEC_LAT + 1);

  logic             busy;
  logic [LAT_W-1:0] remain;

  assign execDone = busy && (remain == LAT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (execAbort) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (execStart) begin
      busy   <= 1'b1;
      remain <= LAT_W'(EXEC_LAT);
    end else if (busy) begin
      if (remain == LAT_W'(1)) busy <= 1'b0;
      remain <= remain - LAT_W'(1);
    end
  end

endmodule

// File: rtl/tpm_fifo_ctrl.sv
module tpm_fifo_ctrl
  import tpm_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic       bitReady,
  input  logic       bitGo,
  input  logic       bitRetry,
  input  logic       bitCancel,
  input  logic       expectMore,
  input  logic       respLeft,
  input  logic       execDone,
  output phase_t     phase,
  output dpCtl_t     dpCtl,
  output logic       execStart,
  output logic       execAbort
);
  phase_t phaseNext;
  logic stsWr, extWr, dataWr, dataRd;
  logic readyReq, goReq, retryReq, cancelReq;

  assign stsWr  = regWr && (regAddr == ADDR_STS);
  assign extWr  = regWr && (regAddr == ADDR_EXT);
  assign dataWr = regWr && (regAddr == ADDR_DATA);
  assign dataRd = regRd && (regAddr == ADDR_DATA);

  assign readyReq  = stsWr && bitReady && (phase != PH_RECV);
  assign goReq     = stsWr && bitGo && (phase == PH_RECV) && !expectMore;
  assign retryReq  = stsWr && bitRetry && !bitReady && (phase == PH_DONE);
  assign cancelReq = extWr && bitCancel && (phase == PH_EXEC);

  always_comb begin
    phaseNext  = phase;
    dpCtl      = '0;
    execStart  = 1'b0;
    execAbort  = readyReq || cancelReq;
    dpCtl.popByte = dataRd && (phase == PH_DONE) && respLeft;
    dpCtl.rewind  = retryReq;
    dpCtl.takeByte = dataWr && expectMore &&
                     ((phase == PH_READY) || (phase == PH_RECV));
    if (readyReq) begin
      phaseNext     = PH_READY;
      dpCtl         = '0;
      dpCtl.clrAll  = 1'b1;
    end else begin
      unique case (phase)
        PH_READY: if (dpCtl.takeByte) phaseNext = PH_RECV;
        PH_RECV: if (goReq) begin
          phaseNext = PH_EXEC;
          execStart = 1'b1;
        end
        PH_EXEC: if (cancelReq) begin
          phaseNext        = PH_DONE;
          dpCtl.markCancel = 1'b1;
        end else if (execDone) begin
          phaseNext    = PH_DONE;
          dpCtl.markOk = 1'b1;
        end
        PH_DONE: phaseNext = PH_DONE;
        default: phaseNext = PH_READY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_READY;
    else       phase <= phaseNext;
  end

  // go while more bytes are still wanted leaves the block loading
  assert_go_blocked_R4: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RECV && stsWr && bitGo && expectMore) |=> (phase == PH_RECV));

  // cancel after the response is ready changes nothing
  assert_cancel_late_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DONE && extWr && bitCancel) |=> (phase == PH_DONE));

  // ready request outside loading lands in Ready
  assert_ready_return_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stsWr && bitReady && phase != PH_RECV) |=> (phase == PH_READY));

  // executor completion can only be observed while executing
  assert_done_in_exec_R5: assert property (@(posedge clk) disable iff (!rstN)
    execDone |-> (phase == PH_EXEC));

endmodule

// File: rtl/tpm_fifo_dp.sv
module tpm_fifo_dp
  import tpm_fifo_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic [7:0] wrData,
  input  phase_t     phase,
  input  dpCtl_t     dpCtl,
  output logic       expectMore,
  output logic       respLeft,
  output logic [7:0] rdData
);
  localparam int RPTR_W = $clog2(RESP_LEN + 1);
  localparam logic [7:0] CANCEL_LO = 8'h09;

  logic [CNT_W-1:0]  byteCnt;
  logic [31:0]       sizeReg;
  logic [7:0]        tagHi, tagLo;
  logic [RPTR_W-1:0] rdPtr;
  logic              cancelled;
  logic [7:0]        respByte;
  logic [7:0]        stsByte;
  logic [31:0]       cntWide;

  assign cntWide    = 32'(byteCnt);
  assign expectMore = (cntWide < 32'(HDR_BYTES)) || (cntWide < sizeReg);
  assign respLeft   = (rdPtr < RPTR_W'(RESP_LEN));

  always_ff @(posedge clk) begin
    if (!rstN || dpCtl.clrAll) begin
      byteCnt   <= '0;
      sizeReg   <= '0;
      tagHi     <= '0;
      tagLo     <= '0;
      rdPtr     <= '0;
      cancelled <= 1'b0;
    end else begin
      if (dpCtl.takeByte) begin
        byteCnt <= byteCnt + CNT_W'(1);
        if (byteCnt == CNT_W'(0)) tagHi <= wrData;
        if (byteCnt == CNT_W'(1)) tagLo <= wrData;
        if (byteCnt >= CNT_W'(2) && byteCnt < CNT_W'(HDR_BYTES))
          sizeReg <= {sizeReg[23:0], wrData};
      end
      if (dpCtl.markCancel || dpCtl.markOk) begin
        cancelled <= dpCtl.markCancel;
        rdPtr     <= '0;
      end else if (dpCtl.rewind) begin
        rdPtr <= '0;
      end else if (dpCtl.popByte) begin
        rdPtr <= rdPtr + RPTR_W'(1);
      end
    end
  end

  always_comb begin
    unique case (rdPtr)
      RPTR_W'(0): respByte = tagHi;
      RPTR_W'(1): respByte = tagLo;
      RPTR_W'(5): respByte = 8'(RESP_LEN);
      RPTR_W'(8): respByte = cancelled ? CANCEL_LO : 8'h00;
      RPTR_W'(9): respByte = cancelled ? CANCEL_LO : 8'h00;
      default:    respByte = 8'h00;
    endcase
  end

  assign stsByte = {1'b1, (phase == PH_READY), 1'b0,
                    (phase == PH_DONE) && respLeft,
                    (phase == PH_RECV) && expectMore,
                    1'b1, 2'b00};

  always_comb begin
    unique case (regAddr)
      ADDR_STS:  rdData = stsByte;
      ADDR_EXT:  rdData = 8'h04;
      ADDR_DATA: rdData = ((phase == PH_DONE) && respLeft) ? respByte : 8'h00;
      default:   rdData = 8'h00;
    endcase
  end

  assert_rdptr_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdPtr <= RPTR_W'(RESP_LEN));

  assert_retry_rewind_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dpCtl.rewind && !dpCtl.clrAll) |=> (rdPtr == '0));

  // once the command is complete the count is frozen until cleared
  assert_count_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!expectMore && !dpCtl.clrAll) |=> $stable(byteCnt));

endmodule

// File: rtl/tpm_fifo_status.sv
module tpm_fifo_status
  import tpm_fifo_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int EXEC_LAT = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] regAddr,
  input  logic       regWr,
  input  logic       regRd,
  input  logic [7:0] wrData,
  output logic [7:0] rdData
);
  phase_t phase;
  dpCtl_t dpCtl;
  logic   expectMore, respLeft, execDone, execStart, execAbort;

  tpm_fifo_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .bitReady(wrData[6]), .bitGo(wrData[5]), .bitRetry(wrData[1]),
    .bitCancel(wrData[0]), .expectMore(expectMore), .respLeft(respLeft),
    .execDone(execDone), .phase(phase), .dpCtl(dpCtl),
    .execStart(execStart), .execAbort(execAbort)
  );

  tpm_fifo_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrData(wrData),
    .phase(phase), .dpCtl(dpCtl), .expectMore(expectMore),
    .respLeft(respLeft), .rdData(rdData)
  );

  tpm_exec_stub #(.EXEC_LAT(EXEC_LAT)) u_exec (
    .clk(clk), .rstN(rstN), .execStart(execStart), .execAbort(execAbort),
    .execDone(execDone)
  );

endmodule

// File: tb/tpm_fifo_status_bench.sv
`timescale 1ns/1ps
module tpm_fifo_status_bench;
  localparam int LAT = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // behavioural model: 0 ready, 1 loading, 2 executing, 3 complete
  int mPh, mCnt, mRdp, mExec;
  longint mSize;
  logic [7:0] mTagA, mTagB;
  bit mCanc;

  always #5 clk = ~clk;

  tpm_fifo_status u_tpm_fifo_status (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .wrData(wrData), .rdData(rdData)
  );

  function automatic bit mWant();
    return (mPh == 1) && (mCnt < 6 || mCnt < mSize);
  endfunction

  function automatic logic [7:0] mResp(int i);
    case (i)
      0: return mTagA;
      1: return mTagB;
      5: return 8'd10;
      8, 9: return mCanc ? 8'h09 : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] mRead(logic [1:0] a);
    case (a)
      2'd0: return {1'b1, mPh == 0, 1'b0, (mPh == 3) && (mRdp < 10), mWant(), 1'b1, 2'b00};
      2'd1: return 8'h04;
      2'd2: return (mPh == 3 && mRdp < 10) ? mResp(mRdp) : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic mClear();
    mPh = 0; mCnt = 0; mRdp = 0; mExec = 0; mSize = 0;
    mTagA = 0; mTagB = 0; mCanc = 0;
  endtask

  task automatic mStep(logic [1:0] a, logic w, logic r, logic [7:0] d);
    int startPh = mPh;
    bit moved = 0;
    bit takeOk = (mPh == 0 || mPh == 1) && (mCnt < 6 || mCnt < mSize);
    if (w && a == 2'd0) begin
      if (d[6] && mPh != 1) begin mClear(); moved = 1; end
      else if (d[5] && mPh == 1 && !mWant()) begin mPh = 2; mExec = LAT; moved = 1; end
      else if (d[1] && mPh == 3) mRdp = 0;
    end else if (w && a == 2'd1) begin
      if (d[0] && mPh == 2) begin mPh = 3; mCanc = 1; mRdp = 0; moved = 1; end
    end else if (w && a == 2'd2 && takeOk) begin
      if (mCnt == 0) mTagA = d;
      if (mCnt == 1) mTagB = d;
      if (mCnt >= 2 && mCnt < 6) mSize = ((mSize << 8) | d) & 64'hFFFF_FFFF;
      mCnt++;
      mPh = 1;
    end
    if (r && a == 2'd2 && mPh == 3 && mRdp < 10) mRdp++;
    if (startPh == 2 && !moved) begin
      if (mExec == 1) begin mPh = 3; mCanc = 0; mRdp = 0; end
      else mExec--;
    end
  endtask

  task automatic step(logic [1:0] a, logic w, logic r, logic [7:0] d, string req);
    logic [7:0] exp;
    @(negedge clk);
    regAddr = a; regWr = w; regRd = r; wrData = d;
    #1;
    exp = mRead(a);
    checks++;
    if (rdData !== exp) begin
      fails++;
      $display("FAIL %s addr=%0d got=%02h exp=%02h t=%0t", req, a, rdData, exp, $time);
    end
    @(posedge clk);
    mStep(a, w, r, d);
  endtask

  task automatic idle(int n, string req);
    for (int i = 0; i < n; i++) step(2'd0, 1'b0, 1'b0, 8'h00, req);
  endtask

  task automatic load(logic [7:0] q[$], string req);
    foreach (q[i]) begin
      step(2'd2, 1'b1, 1'b0, q[i], req);
      step(2'd0, 1'b0, 1'b0, 8'h00, req);
    end
  endtask

  task automatic drain(int n, string req);
    for (int i = 0; i < n; i++) step(2'd2, 1'b0, 1'b1, 8'h00, req);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    mClear();
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state, R2 layout, R9 family
    step(2'd0, 1'b0, 1'b0, 8'h00, "R1");
    step(2'd2, 1'b0, 1'b1, 8'h00, "R1");
    step(2'd3, 1'b0, 1'b0, 8'h00, "R2");
    step(2'd1, 1'b0, 1'b0, 8'h00, "R9");
    // R6 R7 ignored in Ready
    step(2'd1, 1'b1, 1'b0, 8'h01, "R6");
    step(2'd0, 1'b1, 1'b0, 8'h02, "R7");
    idle(1, "R2");

    // command A: size 12
    load('{8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0C}, "R3");
    step(2'd0, 1'b1, 1'b0, 8'h20, "R4");   // early go ignored
    step(2'd0, 1'b1, 1'b0, 8'h40, "R8");   // ready ignored while loading
    step(2'd2, 1'b0, 1'b1, 8'h00, "R10");  // read while loading
    load('{8'h00, 8'h00, 8'h01, 8'h44, 8'h11, 8'h22}, "R3");
    step(2'd2, 1'b1, 1'b0, 8'h99, "R3");   // surplus byte
    step(2'd0, 1'b1, 1'b0, 8'h20, "R4");
    step(2'd2, 1'b1, 1'b0, 8'h55, "R10");  // write while executing
    idle(LAT + 1, "R5");
    drain(12, "R5");
    step(2'd0, 1'b1, 1'b0, 8'h02, "R7");
    drain(4, "R7");
    step(2'd1, 1'b1, 1'b0, 8'h01, "R6");   // cancel too late
    step(2'd2, 1'b1, 1'b0, 8'h66, "R10");
    drain(7, "R6");
    step(2'd0, 1'b1, 1'b0, 8'h40, "R8");
    idle(1, "R8");

    // command B: size 3, header governs
    load('{8'h80, 8'h02, 8'h00, 8'h00, 8'h00, 8'h03}, "R3");
    step(2'd2, 1'b1, 1'b0, 8'h77, "R3");
    step(2'd0, 1'b1, 1'b0, 8'h20, "R4");
    idle(3, "R5");
    step(2'd1, 1'b1, 1'b0, 8'h01, "R6");
    idle(LAT, "R6");
    drain(10, "R6");
    step(2'd0, 1'b1, 1'b0, 8'h40, "R8");

    // command C: cancel lands on the done cycle
    load('{8'hC1, 8'h03, 8'h00, 8'h00, 8'h00, 8'h06}, "R3");
    step(2'd0, 1'b1, 1'b0, 8'h20, "R4");
    idle(LAT - 1, "R5");
    step(2'd1, 1'b1, 1'b0, 8'h01, "R6");
    drain(10, "R6");
    step(2'd0, 1'b1, 1'b0, 8'h40, "R8");

    // command D: ready during execution aborts
    load('{8'hD2, 8'h04, 8'h00, 8'h00, 8'h00, 8'h06}, "R3");
    step(2'd0, 1'b1, 1'b0, 8'h20, "R4");
    idle(2, "R5");
    step(2'd0, 1'b1, 1'b0, 8'h40, "R8");
    idle(LAT + 2, "R8");
    drain(2, "R10");

    // command E: normal completion after abort
    load('{8'hE3, 8'h05, 8'h00, 8'h00, 8'h00, 8'h07, 8'hAB}, "R3");
    step(2'd0, 1'b1, 1'b0, 8'h20, "R4");
    idle(LAT, "R5");
    drain(11, "R5");
    step(2'd0, 1'b0, 1'b0, 8'h00, "R2");

    summary();
  end

endmodule